// File: doc/BRIEF.md
# Configuration Access Port Decoder

This block sits in a host bridge and turns the classic two-port configuration access scheme into requests on a per-function configuration register store. Software first writes a full 32-bit word to the address port. That word selects an enable bit, a bus, a device, a function and a register offset. Later byte, word or dword accesses to a four-byte data window go to the selected function's registers, at the latched offset plus the byte position inside the window.

The block checks every data access before it forwards it. If the enable bit is clear, the bus is not zero, the function is not marked present in a 32x8 presence bitmap, or the access is not aligned to its own size, then a read returns all ones and a write is dropped. Accesses that pass are sent to the store as one dword request with byte enables. Read data comes back right-justified. On the way back, the multi-function flag in the header-type byte is rewritten to match how many functions in the slot are present.

The host issues one access at a time and waits for `host_ack` before it issues the next. `host_rdata` is valid in the cycle `host_ack` is high.

Top module: `cfg_port_decoder`

## Requirements
- R1: Synchronous active-high reset clears the latched address word to zero, which clears the enable bit. During reset `dn_req` and `host_ack` are low.
- R2: An address-port access (`host_sel`=0) updates the latched word only when it is a write with `host_size`=2 (dword) and `host_lane`=0. Byte, word and lane-offset writes leave the latched word unchanged.
- R3: Fields of the latched word: bits 7:0 register offset, 10:8 function, 15:11 device, 23:16 bus, 31 enable.
- R4: The effective offset is the latched offset plus `host_lane`, in 8-bit arithmetic that wraps. `dn_reg` carries bits 7:2 of the effective offset, and `dn_dev`/`dn_func` carry the latched device and function.
- R5: `host_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved. A reserved size is handled as a misaligned access. A read from a present function returns its bytes right-justified, with the bits above the access size zero.
- R6: If the enable bit is clear, the bus is non-zero, or bit `dev*8+func` of `present_map` is 0, a data read returns 32'hFFFFFFFF and a data write causes no `dn_req`.
- R7: If the effective offset is not a multiple of the access size, a data read returns 32'hFFFFFFFF and a data write causes no `dn_req`.
- R8: A forwarded write drives `dn_be` with the size's byte mask (0001, 0011 or 1111) shifted left by the low two offset bits. It drives `dn_wdata` with `host_wdata` shifted left by eight times that amount.
- R9: When a data read covers byte offset 0x0E, bit 7 of that byte is returned as 1 if more than one function of the slot is present in `present_map`, and as 0 otherwise. In a dword read at 0x0C this is bit 23.
- R10: `dn_req` stays high until the cycle `dn_ack` is seen. `host_ack` pulses once per access: one cycle after the request for address-port and rejected accesses, and one cycle after `dn_ack` for forwarded ones.
- R11: An address-port read of any size returns all 32 bits of the latched word. Write acknowledges return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = address port, 1 = data window |
| host_lane | input | 2 | Byte position within the port |
| host_size | input | 2 | Access size code |
| host_wdata | input | 32 | Write data, right-justified |
| host_ack | output | 1 | Access complete |
| host_rdata | output | 32 | Read data, valid with host_ack |
| present_map | input | 256 | Present bit per device*8+function |
| dn_req | output | 1 | Store request, held until dn_ack |
| dn_we | output | 1 | Store write |
| dn_dev | output | 5 | Device number |
| dn_func | output | 3 | Function number |
| dn_reg | output | 6 | Dword index in the function's space |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_ack | input | 1 | Store done, dn_rdata valid |
| dn_rdata | input | 32 | Store read dword |

## Verification
A corrupt latched address shows up at the next address-port readback, and at the `dn_dev`/`dn_func`/`dn_reg` of the next forwarded access. A wrong alignment or presence decision shows up in the same access. The host then sees all ones where register data was expected, or a write that readback later shows was lost or leaked. A lane or mask error appears as shifted or stray bytes in the very read that follows the write. A wrong slot population count flips bit 23 of the first dword read at 0x0C.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DATA_W  = 32;
  localparam int OFF_W   = 8;
  localparam int FUNC_W  = 3;
  localparam int DEV_W   = 5;
  localparam int BUS_W   = 8;
  localparam int REG_W   = OFF_W - 2;
  localparam int NFUNC   = 1 << FUNC_W;
  localparam int NDEV    = 1 << DEV_W;
  localparam int NSLOT_F = NDEV * NFUNC;
  localparam int BE_W    = DATA_W / 8;
  localparam logic [REG_W-1:0] HDR_REG = REG_W'(3);
  localparam int HDR_BIT = 23;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_DWRD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } port_state_e;

  typedef struct packed {
    logic              en;
    logic [6:0]        rsvd;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [OFF_W-1:0]  off;
  } cfg_addr_t;

  function automatic logic [BE_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 4'b0001;
      SZ_WORD: size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_full,
  input  logic [DATA_W-1:0] wr_data,
  output cfg_addr_t         addr_q
);
  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (wr_en && wr_full)
      addr_q <= cfg_addr_t'(wr_data);
  end

  assert_narrow_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_full) |=> $stable(addr_q));

  assert_full_latched_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_full) |=> (addr_q == $past(wr_data)));
endmodule

// File: rtl/cfgp_target_check.sv
module cfgp_target_check
  import cfgp_pkg::*;
(
  input  cfg_addr_t           addr,
  input  logic [1:0]          lane,
  input  logic [1:0]          size,
  input  logic [NSLOT_F-1:0]  present_map,
  output logic [OFF_W-1:0]    eff_off,
  output logic                hit,
  output logic                multi
);
  logic [NDEV-1:0] slot_multi;
  logic            aligned;
  logic            fn_here;

  for (genvar d = 0; d < NDEV; d++) begin : g_slot
    assign slot_multi[d] = ($countones(present_map[d*NFUNC +: NFUNC]) > 1);
  end

  assign eff_off = addr.off + OFF_W'(lane);
  assign fn_here = present_map[{addr.dev, addr.func}];
  assign multi   = slot_multi[addr.dev];

  always_comb begin
    case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_WORD: aligned = ~eff_off[0];
      SZ_DWRD: aligned = (eff_off[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
  end

  assign hit = addr.en && (addr.bus == '0) && fn_here && aligned;
endmodule

// File: rtl/cfgp_wr_lanes.sv
module cfgp_wr_lanes
  import cfgp_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] wdata_sh
);
  assign be       = size_mask(size) << lo;
  assign wdata_sh = wdata << {lo, 3'b000};
endmodule

// File: rtl/cfgp_rd_lanes.sv
module cfgp_rd_lanes
  import cfgp_pkg::*;
(
  input  logic [1:0]        size,
  input  logic [1:0]        lo,
  input  logic              hdr_dword,
  input  logic              multi,
  input  logic [DATA_W-1:0] dword,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] fixed;
  logic [DATA_W-1:0] shifted;
  logic [BE_W-1:0]   keep;

  always_comb begin
    fixed = dword;
    if (hdr_dword)
      fixed[HDR_BIT] = multi;
  end

  assign shifted = fixed >> {lo, 3'b000};
  assign keep    = size_mask(size);

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign rdata[8*i +: 8] = keep[i] ? shifted[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_req,
  input  logic                 host_we,
  input  logic                 host_sel,
  input  logic [1:0]           host_lane,
  input  logic [1:0]           host_size,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic                 host_ack,
  output logic [DATA_W-1:0]    host_rdata,
  input  logic [NSLOT_F-1:0]   present_map,
  output logic                 dn_req,
  output logic                 dn_we,
  output logic [DEV_W-1:0]     dn_dev,
  output logic [FUNC_W-1:0]    dn_func,
  output logic [REG_W-1:0]     dn_reg,
  output logic [BE_W-1:0]      dn_be,
  output logic [DATA_W-1:0]    dn_wdata,
  input  logic                 dn_ack,
  input  logic [DATA_W-1:0]    dn_rdata
);
  port_state_e       state;
  cfg_addr_t         addr_q;
  logic              idle_req;
  logic              addr_wr;
  logic              addr_full;
  logic [OFF_W-1:0]  eff_off;
  logic              hit;
  logic              multi;
  logic [BE_W-1:0]   wr_be;
  logic [DATA_W-1:0] wr_sh;
  logic [1:0]        size_q;
  logic [1:0]        lo_q;
  logic              hdr_q;
  logic              multi_q;
  logic [DATA_W-1:0] rd_al;

  assign idle_req  = host_req && (state == ST_IDLE);
  assign addr_wr   = idle_req && !host_sel && host_we;
  assign addr_full = (host_size == SZ_DWRD) && (host_lane == 2'b00);

  cfgp_addr_reg u_addr (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (addr_wr),
    .wr_full(addr_full),
    .wr_data(host_wdata),
    .addr_q (addr_q)
  );

  cfgp_target_check u_chk (
    .addr       (addr_q),
    .lane       (host_lane),
    .size       (host_size),
    .present_map(present_map),
    .eff_off    (eff_off),
    .hit        (hit),
    .multi      (multi)
  );

  cfgp_wr_lanes u_wl (
    .size    (host_size),
    .lo      (eff_off[1:0]),
    .wdata   (host_wdata),
    .be      (wr_be),
    .wdata_sh(wr_sh)
  );

  cfgp_rd_lanes u_rl (
    .size     (size_q),
    .lo       (lo_q),
    .hdr_dword(hdr_q),
    .multi    (multi_q),
    .dword    (dn_rdata),
    .rdata    (rd_al)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      host_ack   <= 1'b0;
      host_rdata <= '0;
      dn_req     <= 1'b0;
      dn_we      <= 1'b0;
      dn_dev     <= '0;
      dn_func    <= '0;
      dn_reg     <= '0;
      dn_be      <= '0;
      dn_wdata   <= '0;
      size_q     <= SZ_BYTE;
      lo_q       <= 2'b00;
      hdr_q      <= 1'b0;
      multi_q    <= 1'b0;
    end else begin
      host_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (idle_req) begin
            if (!host_sel) begin
              host_ack   <= 1'b1;
              host_rdata <= host_we ? '0 : DATA_W'(addr_q);
            end else if (!hit) begin
              host_ack   <= 1'b1;
              host_rdata <= host_we ? '0 : '1;
            end else begin
              dn_req   <= 1'b1;
              dn_we    <= host_we;
              dn_dev   <= addr_q.dev;
              dn_func  <= addr_q.func;
              dn_reg   <= eff_off[OFF_W-1:2];
              dn_be    <= host_we ? wr_be : '1;
              dn_wdata <= wr_sh;
              size_q   <= host_size;
              lo_q     <= eff_off[1:0];
              hdr_q    <= (eff_off[OFF_W-1:2] == HDR_REG);
              multi_q  <= multi;
              state    <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (dn_ack) begin
            dn_req     <= 1'b0;
            host_ack   <= 1'b1;
            host_rdata <= dn_we ? '0 : rd_al;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!dn_req && !host_ack && (addr_q == '0)));

  assert_only_present_R6: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> (addr_q.en && (addr_q.bus == '0) &&
                present_map[{addr_q.dev, addr_q.func}]));

  assert_be_shape_R8: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_we) |-> (dn_be == 4'b0001 || dn_be == 4'b0010 ||
                           dn_be == 4'b0100 || dn_be == 4'b1000 ||
                           dn_be == 4'b0011 || dn_be == 4'b1100 ||
                           dn_be == 4'b1111));

  assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ack) |=> dn_req);

  assert_ack_after_store_R10: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_ack) |=> (host_ack && !dn_req));
endmodule

// File: tb/cfg_port_decoder_test.sv
module cfg_port_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         host_req, host_we, host_sel;
  logic [1:0]   host_lane, host_size;
  logic [31:0]  host_wdata;
  logic         host_ack;
  logic [31:0]  host_rdata;
  logic [255:0] present_map;
  logic         dn_req, dn_we;
  logic [4:0]   dn_dev;
  logic [2:0]   dn_func;
  logic [5:0]   dn_reg;
  logic [3:0]   dn_be;
  logic [31:0]  dn_wdata;
  logic         dn_ack;
  logic [31:0]  dn_rdata;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_port_decoder uut (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
    .host_lane(host_lane), .host_size(host_size), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .present_map(present_map),
    .dn_req(dn_req), .dn_we(dn_we), .dn_dev(dn_dev), .dn_func(dn_func),
    .dn_reg(dn_reg), .dn_be(dn_be), .dn_wdata(dn_wdata),
    .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  function automatic logic [31:0] dflt(input logic [13:0] k);
    return {2'b10, k[5:0], 3'b000, k[13:9], 5'b00000, k[8:6], 8'h3C};
  endfunction

  // register store model (the function side)
  logic [31:0] store[logic [13:0]];
  int          st_writes = 0;
  logic [3:0]  st_last_be = '0;
  logic [5:0]  st_last_reg = '0;

  always @(posedge clk) begin
    if (rst) begin
      dn_ack   <= 1'b0;
      dn_rdata <= '0;
    end else if (dn_req && !dn_ack) begin
      logic [13:0] k;
      logic [31:0] v;
      k = {dn_dev, dn_func, dn_reg};
      v = store.exists(k) ? store[k] : dflt(k);
      if (dn_we) begin
        for (int i = 0; i < 4; i++)
          if (dn_be[i]) v[8*i +: 8] = dn_wdata[8*i +: 8];
        store[k] = v;
        st_writes++;
        st_last_be  <= dn_be;
        st_last_reg <= dn_reg;
      end
      dn_ack   <= 1'b1;
      dn_rdata <= v;
    end else begin
      dn_ack <= 1'b0;
    end
  end

  // expected model and scoreboard
  logic [31:0] exp_mem[logic [13:0]];
  logic [31:0] shadow = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic bit slot_multi(input logic [4:0] d);
    int n = 0;
    for (int f = 0; f < 8; f++) if (present_map[d*8+f]) n++;
    return n > 1;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && host_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected ack", host_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  task automatic issue(input bit sel, input bit we, input logic [1:0] lane,
                       input logic [1:0] size, input logic [31:0] wd,
                       input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    host_req = 1'b1; host_sel = sel; host_we = we;
    host_lane = lane; host_size = size; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic addr_acc(input bit we, input logic [1:0] lane,
                          input logic [1:0] size, input logic [31:0] wd,
                          input string tag);
    logic [31:0] e;
    e = we ? 32'h0 : shadow;
    if (we && size == 2'd2 && lane == 2'd0) shadow = wd;
    issue(1'b0, we, lane, size, wd, e, tag);
  endtask

  task automatic data_acc(input bit we, input logic [1:0] lane,
                          input logic [1:0] size, input logic [31:0] wd,
                          input string tag);
    logic [7:0]  eff;
    logic [13:0] k;
    logic [31:0] dw, e;
    logic [3:0]  msk;
    bit al, hitv;
    eff = shadow[7:0] + {6'b0, lane};
    al = (size == 2'd0) || (size == 2'd1 && !eff[0]) ||
         (size == 2'd2 && eff[1:0] == 2'b00);
    hitv = shadow[31] && shadow[23:16] == 8'h00 &&
           present_map[shadow[15:8]] && al;
    k = {shadow[15:11], shadow[10:8], eff[7:2]};
    msk = (size == 2'd0) ? 4'b0001 : (size == 2'd1) ? 4'b0011 : 4'b1111;
    dw = exp_mem.exists(k) ? exp_mem[k] : dflt(k);
    if (we) begin
      e = 32'h0;
      if (hitv) begin
        for (int i = 0; i < 4; i++)
          if (msk[i] && (i + eff[1:0]) < 4)
            dw[8*(i+eff[1:0]) +: 8] = wd[8*i +: 8];
        exp_mem[k] = dw;
      end
    end else if (!hitv) begin
      e = 32'hFFFF_FFFF;
    end else begin
      if (eff[7:2] == 6'd3) dw[23] = slot_multi(shadow[15:11]);
      dw = dw >> (8 * eff[1:0]);
      for (int i = 0; i < 4; i++) if (!msk[i]) dw[8*i +: 8] = 8'h00;
      e = dw;
    end
    issue(1'b1, we, lane, size, wd, e, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int w0;
    rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_sel = 1'b0;
    host_lane = 2'd0; host_size = 2'd0; host_wdata = '0;
    present_map = '0;
    present_map[0*8+0] = 1'b1;
    present_map[3*8+0] = 1'b1;
    present_map[3*8+2] = 1'b1;
    present_map[31*8+7] = 1'b1;
    repeat (3) @(negedge clk);
    check(host_ack === 1'b0 && dn_req === 1'b0, "R1 outputs quiet in reset",
          {30'b0, host_ack, dn_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(host_ack === 1'b0 && dn_req === 1'b0, "R1 outputs quiet after reset",
          {30'b0, host_ack, dn_req}, 32'h0);
    addr_acc(1'b0, 2'd0, 2'd2, '0, "R1 latched word zero after reset");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R6 enable clear reads ones");

    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_0000, "R2 full address write ack");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R3 dword read dev0 fn0 reg0");
    addr_acc(1'b1, 2'd0, 2'd0, 32'h0000_0012, "R2 byte write to address port");
    addr_acc(1'b1, 2'd0, 2'd1, 32'h0000_1234, "R2 word write to address port");
    addr_acc(1'b1, 2'd1, 2'd2, 32'h8000_0044, "R2 lane-offset write to address port");
    addr_acc(1'b0, 2'd0, 2'd2, '0, "R2 narrow writes ignored readback");
    addr_acc(1'b0, 2'd1, 2'd0, '0, "R11 byte read of address port is full word");

    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_0010, "R3 select reg 0x10");
    data_acc(1'b1, 2'd0, 2'd2, 32'h1122_3344, "R8 dword write");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R8 dword readback");
    data_acc(1'b1, 2'd1, 2'd0, 32'h0000_00AB, "R8 byte write lane1");
    @(negedge clk);
    check(st_last_be === 4'b0010 && st_last_reg === 6'd4, "R8 byte enables and reg",
          {22'b0, st_last_reg, st_last_be}, {22'b0, 6'd4, 4'b0010});
    data_acc(1'b0, 2'd0, 2'd2, '0, "R8 byte merged readback");
    data_acc(1'b0, 2'd2, 2'd1, '0, "R4 word read at lane2");
    data_acc(1'b0, 2'd3, 2'd0, '0, "R5 byte read lane3 right-justified");
    data_acc(1'b1, 2'd2, 2'd1, 32'hFFFF_BEEF, "R8 word write lane2");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R8 word merged readback");

    data_acc(1'b0, 2'd1, 2'd1, '0, "R7 misaligned word read");
    data_acc(1'b0, 2'd2, 2'd2, '0, "R7 misaligned dword read");
    w0 = st_writes;
    data_acc(1'b1, 2'd3, 2'd1, 32'h0000_5555, "R7 misaligned write ack");
    check(st_writes == w0, "R7 misaligned write not forwarded", st_writes, w0);
    data_acc(1'b0, 2'd0, 2'd2, '0, "R7 contents unchanged after misaligned write");
    data_acc(1'b0, 2'd0, 2'd3, '0, "R5 reserved size reads ones");

    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_0100, "R3 select dev0 fn1 absent");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R6 absent function reads ones");
    w0 = st_writes;
    data_acc(1'b1, 2'd0, 2'd2, 32'hDEAD_BEEF, "R6 absent function write ack");
    check(st_writes == w0, "R6 absent write not forwarded", st_writes, w0);
    addr_acc(1'b1, 2'd0, 2'd2, 32'h8001_0000, "R3 select bus 1");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R6 non-zero bus reads ones");
    addr_acc(1'b1, 2'd0, 2'd2, 32'h0000_0000, "R6 enable cleared");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R6 disabled reads ones");

    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_000C, "R9 select dev0 reg 0x0C");
    data_acc(1'b1, 2'd0, 2'd2, 32'h00FF_0000, "R9 set header byte in store");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R9 single-function dword bit23 cleared");
    data_acc(1'b0, 2'd2, 2'd0, '0, "R9 single-function header byte");
    data_acc(1'b0, 2'd0, 2'd0, '0, "R9 byte not covering header untouched");
    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_180C, "R9 select dev3 fn0 reg 0x0C");
    data_acc(1'b0, 2'd0, 2'd2, '0, "R9 multi-function dword bit23 set");
    data_acc(1'b0, 2'd2, 2'd1, '0, "R9 multi-function header word");
    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_1A0C, "R9 select dev3 fn2 reg 0x0C");
    data_acc(1'b0, 2'd2, 2'd0, '0, "R9 multi-function fn2 header byte");

    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_FFFC, "R4 select dev31 fn7 reg 0xFC");
    data_acc(1'b1, 2'd3, 2'd0, 32'h0000_0077, "R4 byte write at 0xFF");
    @(negedge clk);
    check(st_last_reg === 6'd63 && st_last_be === 4'b1000, "R4 top byte reg and lane",
          {22'b0, st_last_reg, st_last_be}, {22'b0, 6'd63, 4'b1000});
    data_acc(1'b0, 2'd0, 2'd2, '0, "R4 readback at 0xFC");
    addr_acc(1'b1, 2'd0, 2'd2, 32'h8000_FFFF, "R4 select offset 0xFF");
    data_acc(1'b0, 2'd1, 2'd0, '0, "R4 offset wraps to 0x00");
    addr_acc(1'b0, 2'd2, 2'd1, '0, "R11 word read of address port is full word");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10 every access acknowledged once", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule